// File: doc/BRIEF.md
# Comparator Edge Interrupt Controller

This block turns the digital outputs of several analog comparators into interrupt requests. Each channel owns an 8-bit mode register that switches the comparator on, enables its output pin, drives a spare control bit, selects the interrupt edge and, on every channel but the first, holds a 3-bit reference-select field. Each comparator output is synchronized into the clock domain and checked for the chosen edge. A qualifying edge latches that channel's request flag.

The flags sit in one shared flag register and the per-channel interrupt enables sit in an enable register. The enable register also holds a global enable bit. A flag counts toward the CPU interrupt request only when its channel enable and the global enable are both set. While the request is active, the request line carries a fixed vector. Software reads and writes every register over a simple address/data bus with combinational read data and single-cycle writes. Through the same path it can set or clear any flag.

Top module: `cmp_edge_irq_ctrl`

## Requirements
- R1: After reset, every mode register, the flag register (0xA0) and the enable register (0xA1) read 0x00, all control outputs are 0, and irq_req is 0.
- R2: The mode register of channel n sits at address 0x9C+n. Bit 7 drives cmp_en[n], bit 6 drives cmp_oen[n], bit 4 drives cmp_sf[n] and bit 3 is the edge select. All of these read back as written.
- R3: Bits 2:0 of channel 0 always read 0. On channels 1 and 2, bits 2:0 read back as written and drive ref_sel[3n+2:3n].
- R4: Mode bit 5 reads the comparator output of that channel after a two-flop synchronizer. A new level is visible after the second clock edge. Writes to bit 5 have no effect.
- R5: With edge select 1 and the comparator enabled, a low-to-high comparator change sets flag bit n (0xA0 bit n) by the third clock edge. A high-to-low change sets nothing.
- R6: With edge select 0 and the comparator enabled, a high-to-low change sets the flag. A low-to-high change sets nothing.
- R7: A qualifying edge sets the flag even when that channel's interrupt enable bit is 0.
- R8: While mode bit 7 is 0, no comparator change sets the flag. Turning the comparator on while its output differs from its last sampled level does not set the flag.
- R9: Writing 0xA0 loads the flags from the write data bits n: a 1 sets a flag and a 0 clears it. A set flag holds until software writes 0 to it.
- R10: If a qualifying edge and a software write of 0 to the same flag land in the same cycle, the flag ends up set.
- R11: irq_req is 1 exactly when some flag n and enable bit n (0xA1 bit n) are both 1 and the global enable (0xA1 bit 7) is 1.
- R12: irq_vec equals 8 while irq_req is 1 and equals 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_raw | input | 3 | Unsynchronized comparator outputs, one bit per channel |
| bus_addr | input | 8 | Register address |
| bus_wr | input | 1 | Write strobe, one write per cycle |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| cmp_en | output | 3 | Comparator enable per channel |
| cmp_oen | output | 3 | Output-pin enable per channel |
| cmp_sf | output | 3 | Spare control bit per channel |
| ref_sel | output | 9 | Reference-select fields, 3 bits per channel, channel 0 tied to 0 |
| irq_req | output | 1 | CPU interrupt request |
| irq_vec | output | 8 | Interrupt vector, 8 while requesting |

## Verification
Edge detection and a software write to the flag register can both act on the same flag in one cycle. The bench changes a comparator input, counts two clock edges so the edge event is pending, and then presents a clear of the flag register for exactly the next edge. It then reads the flag back and expects 1 together with an active irq_req. As a control, a plain clear with no edge pending must read 0.

// File: rtl/cmp_irq_pkg.sv
package cmp_irq_pkg;

  localparam logic [7:0] ADDR_MODE_BASE = 8'h9C;
  localparam logic [7:0] ADDR_FLAG      = 8'hA0;
  localparam logic [7:0] ADDR_IEN       = 8'hA1;

  localparam int BIT_EN     = 7;
  localparam int BIT_OEN    = 6;
  localparam int BIT_STATUS = 5;
  localparam int BIT_SF     = 4;
  localparam int BIT_SEL    = 3;
  localparam int BIT_GIE    = 7;

  // Mode register bits that keep a written value.
  function automatic logic [7:0] mode_wr_mask(input logic has_rs);
    logic [7:0] m;
    m = 8'hD8;
    if (has_rs) m = m | 8'h07;
    return m;
  endfunction

  // 1 when the sample pair (prev -> cur) is the edge chosen by sel.
  function automatic logic edge_hit(input logic sel, input logic prev, input logic cur);
    return sel ? (~prev & cur) : (prev & ~cur);
  endfunction

  // Request when any enabled flag is up and the global gate is open.
  function automatic logic irq_merge(input logic [7:0] flags, input logic [7:0] ien,
                                     input logic gie);
    return gie & (|(flags & ien));
  endfunction

endpackage

// File: rtl/cmp_sync_edge.sv
module cmp_sync_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic raw,
  input  logic enable,
  input  logic edge_sel,
  output logic sync_o,
  output logic edge_o
);
  import cmp_irq_pkg::*;

  logic [STAGES-1:0] chain_q;
  logic              prev_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= '0;
      prev_q  <= 1'b0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], raw};
      // prev follows the synchronized level in every cycle, so a channel
      // that is switched on sees no stale difference
      prev_q  <= chain_q[STAGES-1];
    end
  end

  assign sync_o = chain_q[STAGES-1];
  assign edge_o = enable & edge_hit(edge_sel, prev_q, sync_o);

endmodule

// File: rtl/cmp_mode_reg.sv
module cmp_mode_reg #(
  parameter bit HAS_RS = 1'b1,
  parameter int RS_W   = 3
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            wr,
  input  logic [7:0]      wdata,
  input  logic            status,
  output logic            en_o,
  output logic            oen_o,
  output logic            sf_o,
  output logic            sel_o,
  output logic [RS_W-1:0] rs_o,
  output logic [7:0]      rdata
);
  import cmp_irq_pkg::*;

  localparam logic [7:0] WMASK = mode_wr_mask(HAS_RS);

  logic [7:0] mode_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)  mode_q <= '0;
    else if (wr) mode_q <= wdata & WMASK;
  end

  assign en_o  = mode_q[BIT_EN];
  assign oen_o = mode_q[BIT_OEN];
  assign sf_o  = mode_q[BIT_SF];
  assign sel_o = mode_q[BIT_SEL];
  assign rs_o  = mode_q[RS_W-1:0];

  always_comb begin
    rdata             = mode_q;
    rdata[BIT_STATUS] = status;
  end

endmodule

// File: rtl/cmp_irq_flags.sv
module cmp_irq_flags #(
  parameter int         NCH = 3,
  parameter logic [7:0] VEC = 8'd8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [NCH-1:0] edge_evt,
  input  logic           flag_wr,
  input  logic           ien_wr,
  input  logic [7:0]     wdata,
  output logic [7:0]     flag_q,
  output logic [7:0]     ien_q,
  output logic           gie,
  output logic           irq_req,
  output logic [7:0]     irq_vec
);
  import cmp_irq_pkg::*;

  localparam logic [7:0] FMASK = 8'((1 << NCH) - 1);
  localparam logic [7:0] EMASK = FMASK | 8'h80;

  logic [7:0] flag_d;

  always_comb begin
    flag_d = flag_wr ? wdata : flag_q;
    // an edge wins over a software clear in the same cycle
    flag_d = (flag_d | 8'(edge_evt)) & FMASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      ien_q  <= '0;
    end else begin
      flag_q <= flag_d;
      if (ien_wr) ien_q <= wdata & EMASK;
    end
  end

  assign gie     = ien_q[BIT_GIE];
  assign irq_req = irq_merge(flag_q & FMASK, ien_q & FMASK, gie);
  assign irq_vec = irq_req ? VEC : 8'd0;

endmodule

// File: rtl/cmp_edge_irq_ctrl.sv
module cmp_edge_irq_ctrl #(
  parameter int         NCH    = 3,
  parameter int         RS_W   = 3,
  parameter int         STAGES = 2,
  parameter logic [7:0] VEC    = 8'd8
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [NCH-1:0]      cmp_raw,
  input  logic [7:0]          bus_addr,
  input  logic                bus_wr,
  input  logic [7:0]          bus_wdata,
  output logic [7:0]          bus_rdata,
  output logic [NCH-1:0]      cmp_en,
  output logic [NCH-1:0]      cmp_oen,
  output logic [NCH-1:0]      cmp_sf,
  output logic [NCH*RS_W-1:0] ref_sel,
  output logic                irq_req,
  output logic [7:0]          irq_vec
);
  import cmp_irq_pkg::*;

  // Named internal events, brought out for the checker
  logic [NCH-1:0] sync_out;
  logic [NCH-1:0] edge_evt;
  logic [NCH-1:0] mode_en;
  logic [NCH-1:0] edge_sel;
  logic [NCH-1:0] mode_hit;
  logic           flag_wr;
  logic           ien_wr;
  logic           glob_en;
  logic [7:0]     flag_q;
  logic [7:0]     ien_q;
  logic [7:0]     mode_rd [NCH];

  assign flag_wr = bus_wr && (bus_addr == ADDR_FLAG);
  assign ien_wr  = bus_wr && (bus_addr == ADDR_IEN);

  for (genvar i = 0; i < NCH; i++) begin : g_ch
    logic [RS_W-1:0] rs;

    assign mode_hit[i] = (bus_addr == ADDR_MODE_BASE + 8'(i));

    cmp_sync_edge #(.STAGES(STAGES)) u_sync (
      .clk     (clk),
      .rst_n   (rst_n),
      .raw     (cmp_raw[i]),
      .enable  (mode_en[i]),
      .edge_sel(edge_sel[i]),
      .sync_o  (sync_out[i]),
      .edge_o  (edge_evt[i])
    );

    cmp_mode_reg #(.HAS_RS(i != 0), .RS_W(RS_W)) u_mode (
      .clk   (clk),
      .rst_n (rst_n),
      .wr    (bus_wr && mode_hit[i]),
      .wdata (bus_wdata),
      .status(sync_out[i]),
      .en_o  (mode_en[i]),
      .oen_o (cmp_oen[i]),
      .sf_o  (cmp_sf[i]),
      .sel_o (edge_sel[i]),
      .rs_o  (rs),
      .rdata (mode_rd[i])
    );

    assign ref_sel[i*RS_W +: RS_W] = rs;
  end

  assign cmp_en = mode_en;

  cmp_irq_flags #(.NCH(NCH), .VEC(VEC)) u_flags (
    .clk     (clk),
    .rst_n   (rst_n),
    .edge_evt(edge_evt),
    .flag_wr (flag_wr),
    .ien_wr  (ien_wr),
    .wdata   (bus_wdata),
    .flag_q  (flag_q),
    .ien_q   (ien_q),
    .gie     (glob_en),
    .irq_req (irq_req),
    .irq_vec (irq_vec)
  );

  always_comb begin
    bus_rdata = 8'h00;
    for (int i = 0; i < NCH; i++) begin
      if (mode_hit[i]) bus_rdata = mode_rd[i];
    end
    if (bus_addr == ADDR_FLAG) bus_rdata = flag_q;
    if (bus_addr == ADDR_IEN)  bus_rdata = ien_q;
  end

endmodule

// File: rtl/cmp_edge_irq_chk.sv
module cmp_edge_irq_chk #(
  parameter int         NCH = 3,
  parameter logic [7:0] VEC = 8'd8
) (
  input logic           clk,
  input logic           rst_n,
  input logic [NCH-1:0] sync_out,
  input logic [NCH-1:0] edge_evt,
  input logic [NCH-1:0] mode_en,
  input logic [NCH-1:0] edge_sel,
  input logic           flag_wr,
  input logic [7:0]     flag_q,
  input logic           glob_en,
  input logic           irq_req,
  input logic [7:0]     irq_vec
);

  for (genvar i = 0; i < NCH; i++) begin : g_a
    // R5: a rising-select event means the new level is high
    assert_rise_dir_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_evt[i] && edge_sel[i]) |-> sync_out[i]);
    // R6: a falling-select event means the new level is low
    assert_fall_dir_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (edge_evt[i] && !edge_sel[i]) |-> !sync_out[i]);
    // R8: a flag rises only from an enabled channel or a software write
    assert_rise_source_R8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(flag_q[i]) |-> ($past(mode_en[i]) || $past(flag_wr)));
    // R10: an edge event always leaves its flag set next cycle
    assert_collision_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
      edge_evt[i] |=> flag_q[i]);
  end

  // R11: no request without the global gate
  assert_irq_gate_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> glob_en);
  // R12: vector tracks the request
  assert_vec_R12: assert property (@(posedge clk) disable iff (!rst_n)
    irq_req |-> (irq_vec == VEC));
  assert_vec_idle_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !irq_req |-> (irq_vec == 8'd0));

endmodule

bind cmp_edge_irq_ctrl cmp_edge_irq_chk #(.NCH(NCH), .VEC(VEC)) u_chk (
  .clk     (clk),
  .rst_n   (rst_n),
  .sync_out(sync_out),
  .edge_evt(edge_evt),
  .mode_en (mode_en),
  .edge_sel(edge_sel),
  .flag_wr (flag_wr),
  .flag_q  (flag_q),
  .glob_en (glob_en),
  .irq_req (irq_req),
  .irq_vec (irq_vec)
);

// File: tb/cmp_edge_irq_ctrl_tb.sv
module cmp_edge_irq_ctrl_tb;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [2:0] cmp_raw = '0;
  logic [7:0] bus_addr = '0;
  logic       bus_wr = 1'b0;
  logic [7:0] bus_wdata = '0;
  logic [7:0] bus_rdata;
  logic [2:0] cmp_en, cmp_oen, cmp_sf;
  logic [8:0] ref_sel;
  logic       irq_req;
  logic [7:0] irq_vec;

  int n_tests = 0;
  int n_fail  = 0;
  bit done    = 1'b0;

  always #4 clk = ~clk;  // 125 MHz

  cmp_edge_irq_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_raw(cmp_raw),
    .bus_addr(bus_addr), .bus_wr(bus_wr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .cmp_en(cmp_en), .cmp_oen(cmp_oen), .cmp_sf(cmp_sf), .ref_sel(ref_sel),
    .irq_req(irq_req), .irq_vec(irq_vec)
  );

  // kind 0: register read, 1: {irq_vec, irq_req}, 2: {ref_sel, cmp_en, cmp_oen, cmp_sf}
  typedef struct {
    int          kind;
    logic [31:0] exp;
    string       tag;
  } item_t;

  item_t exp_q[$];

  // Monitor: pops expected items and compares inside the low phase
  initial begin
    forever begin
      @(negedge clk);
      #1;
      while (exp_q.size() > 0) begin
        item_t it;
        logic [31:0] got;
        it = exp_q.pop_front();
        case (it.kind)
          0:       got = {24'd0, bus_rdata};
          1:       got = {23'd0, irq_vec, irq_req};
          default: got = {14'd0, ref_sel, cmp_en, cmp_oen, cmp_sf};
        endcase
        n_tests++;
        if (got !== it.exp) begin
          n_fail++;
          $display("FAIL %s: got %h expected %h", it.tag, got, it.exp);
        end
      end
    end
  end

  task automatic push(input int kind, input logic [31:0] exp, input string tag);
    item_t it;
    it.kind = kind;
    it.exp  = exp;
    it.tag  = tag;
    exp_q.push_back(it);
  endtask

  task automatic check_reg(input logic [7:0] addr, input logic [7:0] exp, input string tag);
    @(negedge clk);
    bus_addr = addr;
    push(0, {24'd0, exp}, tag);
  endtask

  task automatic check_irq(input logic req, input string tag);
    @(negedge clk);
    push(1, {23'd0, (req ? 8'd8 : 8'd0), req}, tag);
  endtask

  task automatic check_ctl(input logic [17:0] exp, input string tag);
    @(negedge clk);
    push(2, {14'd0, exp}, tag);
  endtask

  task automatic wr_reg(input logic [7:0] addr, input logic [7:0] data);
    @(negedge clk);
    bus_addr  = addr;
    bus_wdata = data;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
  endtask

  task automatic settle();
    repeat (4) @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state
    check_reg(8'h9C, 8'h00, "R1 mode0");
    check_reg(8'h9D, 8'h00, "R1 mode1");
    check_reg(8'h9E, 8'h00, "R1 mode2");
    check_reg(8'hA0, 8'h00, "R1 flags");
    check_reg(8'hA1, 8'h00, "R1 enables");
    check_irq(1'b0, "R1 irq");
    check_ctl(18'd0, "R1 controls");

    // R2 / R3 / R4: field layout and readback, bit 5 writes ignored
    wr_reg(8'h9D, 8'hFF);
    wr_reg(8'h9C, 8'hFF);
    check_reg(8'h9D, 8'hDF, "R2 mode1 readback, R4 bit5 write ignored");
    check_reg(8'h9C, 8'hD8, "R3 ch0 low bits zero");
    check_ctl({9'b000_111_000, 3'b011, 3'b011, 3'b011}, "R2 R3 control outputs");

    // R4 + R5 + R7: rising edge on ch1 with its enable off
    @(negedge clk); cmp_raw[1] = 1'b1;
    @(negedge clk);
    check_reg(8'h9D, 8'hFF, "R4 status visible after sync");
    check_reg(8'hA0, 8'h02, "R7 flag set with enable off");
    check_irq(1'b0, "R11 no request without enables");

    // R5: falling change with rising select sets nothing
    wr_reg(8'hA0, 8'h00);
    check_reg(8'hA0, 8'h00, "R9 software clear");
    @(negedge clk); cmp_raw[1] = 1'b0;
    settle();
    check_reg(8'hA0, 8'h00, "R5 opposite edge ignored");

    // R6: falling select
    wr_reg(8'h9D, 8'h80);
    @(negedge clk); cmp_raw[1] = 1'b1;
    settle();
    check_reg(8'hA0, 8'h00, "R6 rising ignored on falling select");
    @(negedge clk); cmp_raw[1] = 1'b0;
    settle();
    check_reg(8'hA0, 8'h02, "R6 falling edge sets flag");

    // R8: disabled comparator, then enabling with a differing level
    wr_reg(8'hA0, 8'h00);
    wr_reg(8'h9E, 8'h08);
    @(negedge clk); cmp_raw[2] = 1'b1;
    settle();
    check_reg(8'hA0, 8'h00, "R8 disabled channel no flag");
    wr_reg(8'h9E, 8'h88);
    settle();
    check_reg(8'hA0, 8'h00, "R8 enabling gives no false edge");
    @(negedge clk); cmp_raw[2] = 1'b0;
    settle();
    @(negedge clk); cmp_raw[2] = 1'b1;
    settle();
    check_reg(8'hA0, 8'h04, "R8 enabled channel sees edge");

    // R9: software set, hold, clear
    wr_reg(8'hA0, 8'h05);
    check_reg(8'hA0, 8'h05, "R9 software set");
    repeat (10) @(negedge clk);
    check_reg(8'hA0, 8'h05, "R9 flags hold");
    wr_reg(8'hA0, 8'h04);
    check_reg(8'hA0, 8'h04, "R9 selective clear");

    // R11 / R12: combining
    wr_reg(8'hA1, 8'h04);
    check_irq(1'b0, "R11 global gate closed");
    wr_reg(8'hA1, 8'h84);
    check_irq(1'b1, "R11 R12 request with vector");
    wr_reg(8'hA1, 8'h82);
    check_irq(1'b0, "R11 enable on other channel");
    check_reg(8'hA1, 8'h82, "R11 enable readback");

    // R10: edge and software clear in the same cycle
    wr_reg(8'hA1, 8'h84);
    @(negedge clk); cmp_raw[2] = 1'b0;
    settle();
    wr_reg(8'hA0, 8'h00);
    check_reg(8'hA0, 8'h00, "R10 setup clear");
    @(negedge clk); cmp_raw[2] = 1'b1;
    @(posedge clk);
    @(posedge clk);
    @(negedge clk);
    bus_addr  = 8'hA0;
    bus_wdata = 8'h00;
    bus_wr    = 1'b1;
    @(negedge clk);
    bus_wr    = 1'b0;
    check_reg(8'hA0, 8'h04, "R10 edge wins over clear");
    check_irq(1'b1, "R10 request after collision");
    wr_reg(8'hA0, 8'h00);
    check_reg(8'hA0, 8'h00, "R10 control clear");
    check_irq(1'b0, "R12 vector drops with request");

    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    repeat (20000) @(negedge clk);
    if (!done) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
    end
  end

endmodule